// File: doc/BRIEF.md
# Selectable Peripheral Clock-Enable Generator

This block turns one system clock into a set of single-cycle enable strobes for peripheral logic that runs in the same clock domain. Each strobe marks the cycles in which a peripheral should advance. No derived clock is built. A clock-mode input chooses between two sets of base ratios. The core-clock set is used when the system clock comes from a multiplied core source, and the oscillator set is used when it runs from an external oscillator. The base strobes are the SPI reference, the PWM, the timer reference and an internal bus-rate strobe.

Small select fields put programmable post-dividers after two of the base strobes. A 2-bit field sets the SPI strobe rate from the SPI reference. Two 1-bit fields set the two timer strobes from the timer reference. A fixed divide-by-ten stage after the bus-rate strobe gives the UART strobe.

Every stage reloads its ratio only when its own count wraps. Changing a select field or the mode mid-period therefore never shortens the period that is already running.

Top module: `periph_strobe_gen`

## Requirements
- R1: With `ext_mode`=0, `spi_ref_en` fires once every 576 clocks, `pwm_en` once every 768, and `tmr_ref_en` once every 144.
- R2: With `ext_mode`=1, `spi_ref_en` fires once every 96 clocks and `pwm_en` once every 128.
- R3: With `ext_mode`=1, `tmr_ref_en` fires every 26 clocks when `tmr_alt_sel`=1 and every 24 clocks when it is 0. With `ext_mode`=0, `tmr_alt_sel` has no effect on `tmr_ref_en`.
- R4: `spi_sel` sets how many `spi_ref_en` strobes make one `spi_en` strobe: 0 gives 32, 1 gives 8, 2 gives 2 and 3 gives 1.
- R5: `tmr1_sel` and `tmr2_sel` each act on their own timer strobe. A value of 0 makes one strobe for every 256 `tmr_ref_en` strobes, and a value of 1 makes one strobe for every `tmr_ref_en` strobe.
- R6: An internal bus-rate strobe fires every 2 clocks with `ext_mode`=0 and on every clock with `ext_mode`=1. `uart_en` fires once every 10 bus-rate strobes.
- R7: A stage takes a new mode or select value only when it emits its own strobe, or at reset. The period in progress completes at its old length.
- R8: `rst` is synchronous and active high. After any clock edge at which `rst` is high, every strobe is low and every count restarts from zero.
- R9: After reset is released, a base stage of ratio N first strobes in the cycle after the Nth clock edge. A post-divided strobe rises one cycle after the reference strobe that completes its count.
- R10: No strobe is ever high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 0 selects the core-clock ratios, 1 selects the oscillator ratios |
| tmr_alt_sel | input | 1 | Timer reference ratio choice in oscillator mode (1 gives 26, 0 gives 24) |
| spi_sel | input | 2 | SPI post-divider select |
| tmr1_sel | input | 1 | Timer 1 post-divider select |
| tmr2_sel | input | 1 | Timer 2 post-divider select |
| spi_ref_en | output | 1 | SPI reference strobe |
| spi_en | output | 1 | SPI strobe |
| pwm_en | output | 1 | PWM strobe |
| tmr_ref_en | output | 1 | Timer reference strobe |
| tmr1_en | output | 1 | Timer 1 strobe |
| tmr2_en | output | 1 | Timer 2 strobe |
| uart_en | output | 1 | UART strobe |

## Verification
Every strobe is registered. A base strobe shows the state of its counter one cycle after the edge at which that counter wrapped. A post-divided strobe, and the UART strobe, arrive one cycle after the reference strobe that completes their count.

The bench model advances at each rising edge, using the inputs present at that edge, and holds its outputs for the same one-cycle delay. The design's strobes are compared against it on the falling edge. Inputs change just after a rising edge, so a mode or select change lands mid-period and the wrap-only reload of R7 is tested in every phase. A reset in the middle of the run checks the restart latency of R8 and R9.

// File: rtl/periph_strobe_pkg.sv
package periph_strobe_pkg;

    typedef enum logic {
        MODE_CORE = 1'b0,
        MODE_OSC  = 1'b1
    } clk_mode_e;

    typedef struct packed {
        logic spi_ref;
        logic pwm;
        logic tmr_ref;
        logic bus;
        logic spi;
        logic tmr1;
        logic tmr2;
        logic uart;
    } strobe_t;

    localparam int CORE_SPI_RATIO  = 576;
    localparam int CORE_PWM_RATIO  = 768;
    localparam int CORE_TMR_RATIO  = 144;
    localparam int CORE_BUS_RATIO  = 2;
    localparam int OSC_SPI_RATIO   = 96;
    localparam int OSC_PWM_RATIO   = 128;
    localparam int OSC_TMR_RATIO_0 = 24;
    localparam int OSC_TMR_RATIO_1 = 26;
    localparam int OSC_BUS_RATIO   = 1;
    localparam int UART_RATIO      = 10;
    localparam int TMR_SLOW_RATIO  = 256;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Fixed SPI post-divider encoding
    function automatic int spi_post_ratio(input logic [1:0] sel);
        case (sel)
            2'd0:    return 32;
            2'd1:    return 8;
            2'd2:    return 2;
            default: return 1;
        endcase
    endfunction

    function automatic int tmr_post_ratio(input logic sel, input int slow);
        return sel ? 1 : slow;
    endfunction

endpackage

// File: rtl/strobe_divider.sv
module strobe_divider #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          strobe
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] cur_lim;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            cur_lim <= limit;
            strobe  <= 1'b0;
        end else begin
            strobe <= 1'b0;
            if (tick) begin
                if (cnt == cur_lim) begin
                    cnt     <= '0;
                    cur_lim <= limit;   // new ratio only at wrap
                    strobe  <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ratio_decode.sv
module ratio_decode
    import periph_strobe_pkg::*;
#(
    parameter int CW         = 10,
    parameter int C_SPI      = CORE_SPI_RATIO,
    parameter int C_PWM      = CORE_PWM_RATIO,
    parameter int C_TMR      = CORE_TMR_RATIO,
    parameter int C_BUS      = CORE_BUS_RATIO,
    parameter int O_SPI      = OSC_SPI_RATIO,
    parameter int O_PWM      = OSC_PWM_RATIO,
    parameter int O_TMR0     = OSC_TMR_RATIO_0,
    parameter int O_TMR1     = OSC_TMR_RATIO_1,
    parameter int O_BUS      = OSC_BUS_RATIO,
    parameter int UART_DIV   = UART_RATIO,
    parameter int TMR_SLOW   = TMR_SLOW_RATIO
) (
    input  clk_mode_e     mode,
    input  logic          tmr_alt,
    input  logic [1:0]    spi_sel,
    input  logic [1:0]    tmr_sel,
    output logic [CW-1:0] lim_spi_ref,
    output logic [CW-1:0] lim_pwm,
    output logic [CW-1:0] lim_tmr_ref,
    output logic [CW-1:0] lim_bus,
    output logic [CW-1:0] lim_spi,
    output logic [CW-1:0] lim_tmr [2],
    output logic [CW-1:0] lim_uart
);
    int tmr_osc;

    always_comb begin
        tmr_osc = tmr_alt ? O_TMR1 : O_TMR0;
        if (mode == MODE_OSC) begin
            lim_spi_ref = CW'(O_SPI - 1);
            lim_pwm     = CW'(O_PWM - 1);
            lim_tmr_ref = CW'(tmr_osc - 1);
            lim_bus     = CW'(O_BUS - 1);
        end else begin
            lim_spi_ref = CW'(C_SPI - 1);
            lim_pwm     = CW'(C_PWM - 1);
            lim_tmr_ref = CW'(C_TMR - 1);
            lim_bus     = CW'(C_BUS - 1);
        end
        lim_spi  = CW'(spi_post_ratio(spi_sel) - 1);
        lim_uart = CW'(UART_DIV - 1);
    end

    for (genvar t = 0; t < 2; t++) begin : g_tmr_lim
        assign lim_tmr[t] = CW'(tmr_post_ratio(tmr_sel[t], TMR_SLOW) - 1);
    end
endmodule

// File: rtl/periph_strobe_gen.sv
module periph_strobe_gen
    import periph_strobe_pkg::*;
#(
    parameter int C_SPI    = CORE_SPI_RATIO,
    parameter int C_PWM    = CORE_PWM_RATIO,
    parameter int C_TMR    = CORE_TMR_RATIO,
    parameter int C_BUS    = CORE_BUS_RATIO,
    parameter int O_SPI    = OSC_SPI_RATIO,
    parameter int O_PWM    = OSC_PWM_RATIO,
    parameter int O_TMR0   = OSC_TMR_RATIO_0,
    parameter int O_TMR1   = OSC_TMR_RATIO_1,
    parameter int O_BUS    = OSC_BUS_RATIO,
    parameter int UART_DIV = UART_RATIO,
    parameter int TMR_SLOW = TMR_SLOW_RATIO
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_mode,
    input  logic       tmr_alt_sel,
    input  logic [1:0] spi_sel,
    input  logic       tmr1_sel,
    input  logic       tmr2_sel,
    output logic       spi_ref_en,
    output logic       spi_en,
    output logic       pwm_en,
    output logic       tmr_ref_en,
    output logic       tmr1_en,
    output logic       tmr2_en,
    output logic       uart_en
);
    localparam int MAX_BASE = imax(imax(imax(C_SPI, C_PWM), imax(C_TMR, C_BUS)),
                                   imax(imax(O_SPI, O_PWM), imax(imax(O_TMR0, O_TMR1), O_BUS)));
    localparam int MAX_POST = imax(imax(32, TMR_SLOW), UART_DIV);
    localparam int CW       = $clog2(imax(MAX_BASE, MAX_POST)) + 1;

    clk_mode_e     mode;
    strobe_t       stb;
    logic [CW-1:0] lim_spi_ref, lim_pwm, lim_tmr_ref, lim_bus, lim_spi, lim_uart;
    logic [CW-1:0] lim_tmr [2];
    logic [1:0]    tmr_sel;
    logic [1:0]    tmr_stb;

    assign mode    = clk_mode_e'(ext_mode);
    assign tmr_sel = {tmr2_sel, tmr1_sel};

    ratio_decode #(
        .CW(CW), .C_SPI(C_SPI), .C_PWM(C_PWM), .C_TMR(C_TMR), .C_BUS(C_BUS),
        .O_SPI(O_SPI), .O_PWM(O_PWM), .O_TMR0(O_TMR0), .O_TMR1(O_TMR1),
        .O_BUS(O_BUS), .UART_DIV(UART_DIV), .TMR_SLOW(TMR_SLOW)
    ) i_decode (
        .mode        (mode),
        .tmr_alt     (tmr_alt_sel),
        .spi_sel     (spi_sel),
        .tmr_sel     (tmr_sel),
        .lim_spi_ref (lim_spi_ref),
        .lim_pwm     (lim_pwm),
        .lim_tmr_ref (lim_tmr_ref),
        .lim_bus     (lim_bus),
        .lim_spi     (lim_spi),
        .lim_tmr     (lim_tmr),
        .lim_uart    (lim_uart)
    );

    // Base stages advance on every clock
    strobe_divider #(.CW(CW)) i_spi_ref (
        .clk(clk), .rst(rst), .tick(1'b1), .limit(lim_spi_ref), .strobe(stb.spi_ref));
    strobe_divider #(.CW(CW)) i_pwm (
        .clk(clk), .rst(rst), .tick(1'b1), .limit(lim_pwm), .strobe(stb.pwm));
    strobe_divider #(.CW(CW)) i_tmr_ref (
        .clk(clk), .rst(rst), .tick(1'b1), .limit(lim_tmr_ref), .strobe(stb.tmr_ref));
    strobe_divider #(.CW(CW)) i_bus (
        .clk(clk), .rst(rst), .tick(1'b1), .limit(lim_bus), .strobe(stb.bus));

    // Post stages advance on their reference strobe
    strobe_divider #(.CW(CW)) i_spi (
        .clk(clk), .rst(rst), .tick(stb.spi_ref), .limit(lim_spi), .strobe(stb.spi));
    strobe_divider #(.CW(CW)) i_uart (
        .clk(clk), .rst(rst), .tick(stb.bus), .limit(lim_uart), .strobe(stb.uart));

    for (genvar t = 0; t < 2; t++) begin : g_tmr
        strobe_divider #(.CW(CW)) i_tmr (
            .clk(clk), .rst(rst), .tick(stb.tmr_ref), .limit(lim_tmr[t]),
            .strobe(tmr_stb[t]));
    end

    assign stb.tmr1 = tmr_stb[0];
    assign stb.tmr2 = tmr_stb[1];

    assign spi_ref_en = stb.spi_ref;
    assign spi_en     = stb.spi;
    assign pwm_en     = stb.pwm;
    assign tmr_ref_en = stb.tmr_ref;
    assign tmr1_en    = stb.tmr1;
    assign tmr2_en    = stb.tmr2;
    assign uart_en    = stb.uart;
endmodule

// File: rtl/periph_strobe_chk.sv
module periph_strobe_chk (
    input logic       clk,
    input logic       rst,
    input logic       spi_ref_en,
    input logic       spi_en,
    input logic       pwm_en,
    input logic       tmr_ref_en,
    input logic       tmr1_en,
    input logic       tmr2_en,
    input logic       uart_en
);
    // R8: every strobe is low after a reset edge
    p_reset_quiet_r8: assert property (@(posedge clk)
        rst |=> !(spi_ref_en | spi_en | pwm_en | tmr_ref_en | tmr1_en | tmr2_en | uart_en));

    // R10: strobes last one cycle
    p_single_spi_ref_r10: assert property (@(posedge clk) disable iff (rst)
        spi_ref_en |=> !spi_ref_en);
    p_single_spi_r10: assert property (@(posedge clk) disable iff (rst)
        spi_en |=> !spi_en);
    p_single_tmr1_r10: assert property (@(posedge clk) disable iff (rst)
        tmr1_en |=> !tmr1_en);
    p_single_uart_r10: assert property (@(posedge clk) disable iff (rst)
        uart_en |=> !uart_en);
    p_single_pwm_r10: assert property (@(posedge clk) disable iff (rst)
        pwm_en |=> !pwm_en);

    // R9: post strobes follow their reference strobe by one cycle
    p_spi_follows_r9: assert property (@(posedge clk) disable iff (rst)
        spi_en |-> $past(spi_ref_en));
    p_tmr1_follows_r9: assert property (@(posedge clk) disable iff (rst)
        tmr1_en |-> $past(tmr_ref_en));
    p_tmr2_follows_r9: assert property (@(posedge clk) disable iff (rst)
        tmr2_en |-> $past(tmr_ref_en));
endmodule

bind periph_strobe_gen periph_strobe_chk i_strobe_chk (
    .clk        (clk),
    .rst        (rst),
    .spi_ref_en (spi_ref_en),
    .spi_en     (spi_en),
    .pwm_en     (pwm_en),
    .tmr_ref_en (tmr_ref_en),
    .tmr1_en    (tmr1_en),
    .tmr2_en    (tmr2_en),
    .uart_en    (uart_en)
);

// File: tb/test_periph_strobe_gen.sv
`timescale 1ns/100ps
module test_periph_strobe_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_mode = 1'b0;
    logic       tmr_alt_sel = 1'b0;
    logic [1:0] spi_sel = 2'd3;
    logic       tmr1_sel = 1'b1;
    logic       tmr2_sel = 1'b0;
    logic       spi_ref_en, spi_en, pwm_en, tmr_ref_en, tmr1_en, tmr2_en, uart_en;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit started = 0;
    bit done    = 0;

    // Model stage order: 0 spi_ref, 1 pwm, 2 tmr_ref, 3 bus, 4 spi, 5 tmr1, 6 tmr2, 7 uart
    int rem [8];
    bit mo  [8];
    bit prev [8];

    always #2.5 clk = ~clk;

    periph_strobe_gen i_periph_strobe_gen (
        .clk(clk), .rst(rst), .ext_mode(ext_mode), .tmr_alt_sel(tmr_alt_sel),
        .spi_sel(spi_sel), .tmr1_sel(tmr1_sel), .tmr2_sel(tmr2_sel),
        .spi_ref_en(spi_ref_en), .spi_en(spi_en), .pwm_en(pwm_en),
        .tmr_ref_en(tmr_ref_en), .tmr1_en(tmr1_en), .tmr2_en(tmr2_en),
        .uart_en(uart_en)
    );

    // Period of each stage for the current inputs (R1..R6)
    function automatic int period_of(input int i);
        case (i)
            0: return ext_mode ? 96 : 576;                            // R1 R2
            1: return ext_mode ? 128 : 768;                           // R1 R2
            2: return ext_mode ? (tmr_alt_sel ? 26 : 24) : 144;       // R1 R3
            3: return ext_mode ? 1 : 2;                               // R6
            4: return (spi_sel == 2'd0) ? 32 : (spi_sel == 2'd1) ? 8 :
                      (spi_sel == 2'd2) ? 2 : 1;                      // R4
            5: return tmr1_sel ? 1 : 256;                             // R5
            6: return tmr2_sel ? 1 : 256;                             // R5
            default: return 10;                                       // R6
        endcase
    endfunction

    // Reference model: counts down, takes new period only when it fires (R7)
    always @(posedge clk) begin
        bit tk [8];
        bit nx [8];
        if (rst) begin
            for (int i = 0; i < 8; i++) begin
                rem[i] = period_of(i);
                mo[i]  = 1'b0;
            end
        end else begin
            tk[0] = 1'b1; tk[1] = 1'b1; tk[2] = 1'b1; tk[3] = 1'b1;
            tk[4] = mo[0]; tk[5] = mo[2]; tk[6] = mo[2]; tk[7] = mo[3];
            for (int i = 0; i < 8; i++) begin
                nx[i] = 1'b0;
                if (tk[i]) begin
                    if (rem[i] == 1) begin
                        nx[i]  = 1'b1;
                        rem[i] = period_of(i);
                    end else begin
                        rem[i] = rem[i] - 1;
                    end
                end
            end
            for (int i = 0; i < 8; i++) mo[i] = nx[i];
        end
        started = 1'b1;
        cycles  = cycles + 1;
    end

    task automatic cmp(input string nm, input string req, input logic act, input bit exp);
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, nm, cycles, act, exp);
        end
    endtask

    task automatic one_cycle(input string nm, input int k, input logic act);
        if (act === 1'b1 && prev[k]) begin
            errors = errors + 1;
            $display("FAIL R10 %s high two cycles at cycle %0d: actual 1 expected 0", nm, cycles);
        end
        prev[k] = (act === 1'b1);
    endtask

    // Compare on the falling edge, every cycle
    always @(negedge clk) begin
        if (started && !done) begin
            vectors = vectors + 1;
            cmp("spi_ref_en", "R1 R2 R8 R9", spi_ref_en, mo[0]);
            cmp("pwm_en",     "R1 R2 R8 R9", pwm_en,     mo[1]);
            cmp("tmr_ref_en", "R1 R3 R7",    tmr_ref_en, mo[2]);
            cmp("spi_en",     "R4 R7 R9",    spi_en,     mo[4]);
            cmp("tmr1_en",    "R5 R9",       tmr1_en,    mo[5]);
            cmp("tmr2_en",    "R5 R9",       tmr2_en,    mo[6]);
            cmp("uart_en",    "R6",          uart_en,    mo[7]);
            one_cycle("spi_ref_en", 0, spi_ref_en);
            one_cycle("pwm_en",     1, pwm_en);
            one_cycle("tmr_ref_en", 2, tmr_ref_en);
            one_cycle("spi_en",     4, spi_en);
            one_cycle("tmr1_en",    5, tmr1_en);
            one_cycle("tmr2_en",    6, tmr2_en);
            one_cycle("uart_en",    7, uart_en);
            // R8: reset state at the ports
            if (rst && $past(rst) && (spi_ref_en | spi_en | pwm_en | tmr_ref_en |
                                      tmr1_en | tmr2_en | uart_en) !== 1'b0) begin
                errors = errors + 1;
                $display("FAIL R8 strobe high in reset: actual 1 expected 0");
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_up;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        run(4);
        rst = 1'b0;
        // Core mode, fast SPI, timer1 undivided, timer2 slow; alt select toggled (R3 ignore)
        run(20000);
        tmr_alt_sel = 1'b1;
        run(20000);
        // Slowest SPI post ratio, change mid-period (R4 R7)
        spi_sel  = 2'd0;
        tmr1_sel = 1'b0;
        tmr2_sel = 1'b1;
        run(40000);
        // Oscillator mode, alt 0 (R2 R3 R6)
        ext_mode    = 1'b1;
        tmr_alt_sel = 1'b0;
        spi_sel     = 2'd1;
        run(15000);
        // Alt 1, SPI divide by 2
        tmr_alt_sel = 1'b1;
        spi_sel     = 2'd2;
        tmr1_sel    = 1'b1;
        run(10000);
        // Mid-run reset and restart latency (R8 R9)
        rst = 1'b1;
        run(3);
        rst      = 1'b0;
        spi_sel  = 2'd0;
        tmr2_sel = 1'b0;
        run(10000);
        // Back to core mode mid-period (R7)
        ext_mode = 1'b0;
        spi_sel  = 2'd3;
        run(5000);
        finish_up();
    end

    // Watchdog
    initial begin
        #(5.0 * 190000);
        errors = errors + 1;
        $display("FAIL watchdog expired: actual running expected finished");
        finish_up();
    end
endmodule